// File: doc/BRIEF.md
# Nonvolatile SRAM store/recall controller

This block is a synchronous controller for a 512-byte working memory that is paired with a shadow array. The shadow array keeps its contents across power loss. In memory mode the block acts as a plain static RAM. Three active-low strobes control it: chip enable, output enable and write enable. A write is taken into the array on the cycle in which the write strobes end.

In nonvolatile mode the block copies the whole working array into the shadow array (STORE) or copies it back (RECALL). The copy moves one byte per clock. The mode lasts a fixed, parameterised number of cycles, and normal access is locked out for that time.

A digital supply-good input takes the place of an analog threshold comparator. When it falls, a STORE runs, but only if something was written since the last copy. When it rises again, a RECALL runs. A RECALL also runs after reset. Software can ask for a STORE through a request input, but only while the supply is good.

Top module: `nvsram_ctrl`

## Requirements
- R1: In memory mode, a cycle with ce_n=0, oe_n=0 and we_n=1 puts the byte at addr on dout with dout_en=1 in the next cycle. Any other cycle gives dout=0 and dout_en=0 in the next cycle.
- R2: While ce_n and we_n are both 0, addr and din are sampled on every cycle. The last sampled byte is committed on the first cycle in which either strobe is high, and a read in that same cycle already returns it.
- R3: A cycle with we_n=0 gives dout_en=0 in the next cycle, even if oe_n and ce_n are 0.
- R4: After reset, once supply_ok=1, a RECALL starts. busy is 1 for exactly RECALL_CYCLES cycles, and afterwards the working array equals the shadow array.
- R5: A one-cycle sw_store pulse while idle with supply_ok=1 starts a STORE. busy is 1 for exactly STORE_CYCLES cycles, and afterwards the shadow array equals the working array.
- R6: sw_store has no effect while supply_ok=0, and busy stays 0.
- R7: A 1-to-0 step of supply_ok while idle starts a STORE only if a write was committed, or was still in progress, since the last STORE or RECALL ended. Otherwise busy stays 0.
- R8: Every 1-to-0 step of supply_ok latches a RECALL request. The request is carried out as soon as supply_ok is 1 again and the block is idle.
- R9: While busy=1, dout_en is 0 and write strobes commit nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| supply_ok | input | 1 | Digital supply-good indication |
| sw_store | input | 1 | Software STORE request |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_en | output | 1 | Read data valid / output driver on |
| busy | output | 1 | High during STORE or RECALL |

## Verification
The assertions run on every cycle. They check the following:
- output blanking while write enable is low or while a copy is running;
- that no commit ever lands during a copy;
- that a STORE cannot start while the supply stays low, or from a clean state without a request;
- that a pending RECALL starts once the supply is good;
- that the copy counter stays inside its window.

Only the bench scenarios can show the rest: that data written before a STORE returns intact after a supply dip and RECALL, that a write still in flight at the supply fall is saved, and that a write attempted during a copy is lost. The same holds for the exact length of each busy window and for the last-sample rule of a multi-cycle write.

// File: rtl/nvsram_pkg.sv
// Shared types for the nonvolatile SRAM controller.
package nvsram_pkg;
    // Operating mode: memory access or one of the two copy directions.
    typedef enum logic [1:0] {
        NV_IDLE   = 2'd0,
        NV_STORE  = 2'd1,
        NV_RECALL = 2'd2
    } nv_mode_t;
endpackage

// File: rtl/nv_arrays.sv
// Working and shadow byte arrays.
// Does: asynchronous read of the working array; memory-mode writes; one
// byte per cycle copy in either direction, indexed by the sequencer count.
// Assumes: copy indices at or above DEPTH are idle padding and are ignored.
module nv_arrays #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              store_cp,
    input  logic              recall_cp,
    input  logic [CNT_W-1:0]  cp_idx
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] work   [DEPTH];
    logic [DATA_W-1:0] shadow [DEPTH];
    logic              cp_ok;
    logic [ADDR_W-1:0] cp_a;

    assign cp_ok   = (cp_idx < CNT_W'(DEPTH));
    assign cp_a    = cp_idx[ADDR_W-1:0];
    assign rd_data = work[rd_addr];

    // Working array: recall copy has priority over a memory-mode write.
    always_ff @(posedge clk) begin
        if (recall_cp && cp_ok)
            work[cp_a] <= shadow[cp_a];
        else if (wr_en)
            work[wr_addr] <= wr_data;
    end

    // Shadow array: written only by the store copy.
    always_ff @(posedge clk) begin
        if (store_cp && cp_ok)
            shadow[cp_a] <= work[cp_a];
    end
endmodule

// File: rtl/nv_access.sv
// Memory-mode access path.
// Does: decodes read and write strobes. It samples write address and data
// while a write is held and commits them when the write ends, or when a
// copy begins. It registers read data, bypassing a same-cycle commit.
// Assumes: busy and start come from the sequencer; start is only high while idle.
module nv_access #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              start,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              wr_pend,
    output logic              commit,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [DATA_W-1:0] commit_data
);
    logic wr_now;
    logic rd_now;

    assign wr_now = ~ce_n & ~we_n & ~busy;
    assign rd_now = ~ce_n & ~oe_n & we_n & ~busy;
    assign commit = wr_pend & (~wr_now | start);

    // Track a write in progress; a copy start closes it.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_pend <= 1'b0;
        else        wr_pend <= wr_now & ~start;
    end

    // Sample address and data on every cycle of a held write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_addr <= '0;
            commit_data <= '0;
        end else if (wr_now) begin
            commit_addr <= addr;
            commit_data <= din;
        end
    end

    // Registered read output, zero when not reading.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_en <= 1'b0;
        end else if (rd_now) begin
            dout    <= (commit && commit_addr == addr) ? commit_data : rd_data;
            dout_en <= 1'b1;
        end else begin
            dout    <= '0;
            dout_en <= 1'b0;
        end
    end

    assert_we_blanks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> !dout_en);
    assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !dout_en);
    assert_no_commit_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !busy);
endmodule

// File: rtl/nv_seq.sv
// Store/recall sequencer.
// Does: detects supply loss and return and keeps the dirty and recall-pending
// flags. It chooses when a STORE or RECALL starts and counts each copy window.
// Assumes: STORE_CYC and RECALL_CYC are at least the array depth.
module nv_seq
    import nvsram_pkg::*;
#(
    parameter int STORE_CYC  = 520,
    parameter int RECALL_CYC = 530,
    parameter int CNT_W      = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    input  logic             sw_store,
    input  logic             wr_pend,
    input  logic             commit,
    output nv_mode_t         mode,
    output logic [CNT_W-1:0] cnt,
    output logic             start
);
    nv_mode_t mode_d;
    logic     supply_q;
    logic     dirty;
    logic     recall_req;
    logic     fall;
    logic     last;

    assign fall  = supply_q & ~supply_ok;
    assign start = (mode == NV_IDLE) && (mode_d != NV_IDLE);
    assign last  = (mode == NV_STORE  && cnt == CNT_W'(STORE_CYC - 1)) ||
                   (mode == NV_RECALL && cnt == CNT_W'(RECALL_CYC - 1));

    // Pick the next copy: supply-loss store, pending recall, then software store.
    always_comb begin
        mode_d = mode;
        if (mode == NV_IDLE) begin
            if (fall && (dirty || wr_pend))    mode_d = NV_STORE;
            else if (recall_req && supply_ok)  mode_d = NV_RECALL;
            else if (sw_store && supply_ok)    mode_d = NV_STORE;
        end
    end

    // Mode register and copy counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= NV_IDLE;
            cnt  <= '0;
        end else if (start) begin
            mode <= mode_d;
            cnt  <= '0;
        end else if (last) begin
            mode <= NV_IDLE;
            cnt  <= '0;
        end else if (mode != NV_IDLE) begin
            cnt  <= cnt + 1'b1;
        end
    end

    // Supply history, dirty flag and latched recall request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            supply_q   <= 1'b0;
            dirty      <= 1'b0;
            recall_req <= 1'b1;
        end else begin
            supply_q <= supply_ok;
            if (last)        dirty <= 1'b0;
            else if (commit) dirty <= 1'b1;
            if (fall)                                   recall_req <= 1'b1;
            else if (start && mode_d == NV_RECALL)      recall_req <= 1'b0;
        end
    end

    assert_sw_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == NV_IDLE && !supply_ok && !supply_q) |=> (mode != NV_STORE));
    assert_clean_no_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == NV_IDLE && !dirty && !wr_pend && !(sw_store && supply_ok))
        |=> (mode != NV_STORE));
    assert_recall_on_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == NV_IDLE && recall_req && supply_ok) |=> (mode == NV_RECALL));
    assert_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == NV_STORE) |-> (cnt < CNT_W'(STORE_CYC)));
    assert_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == NV_RECALL) |-> (cnt < CNT_W'(RECALL_CYC)));
endmodule

// File: rtl/nvsram_ctrl.sv
// Top of the nonvolatile SRAM controller.
// Does: ties together the access path, the sequencer and the two arrays.
// busy is high in either copy mode.
// Assumes: the copy window parameters are not smaller than 2**ADDR_W.
module nvsram_ctrl
    import nvsram_pkg::*;
#(
    parameter int ADDR_W        = 9,
    parameter int DATA_W        = 8,
    parameter int STORE_CYCLES  = 520,
    parameter int RECALL_CYCLES = 530
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              supply_ok,
    input  logic              sw_store,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              busy
);
    localparam int MAX_CYC = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    nv_mode_t          mode;
    logic [CNT_W-1:0]  cnt;
    logic              start;
    logic              wr_pend;
    logic              commit;
    logic [ADDR_W-1:0] commit_addr;
    logic [DATA_W-1:0] commit_data;
    logic [DATA_W-1:0] rd_data;

    assign busy = (mode != NV_IDLE);

    nv_seq #(
        .STORE_CYC (STORE_CYCLES),
        .RECALL_CYC(RECALL_CYCLES),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .supply_ok(supply_ok),
        .sw_store (sw_store),
        .wr_pend  (wr_pend),
        .commit   (commit),
        .mode     (mode),
        .cnt      (cnt),
        .start    (start)
    );

    nv_access #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_access (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .start      (start),
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .we_n       (we_n),
        .addr       (addr),
        .din        (din),
        .rd_data    (rd_data),
        .dout       (dout),
        .dout_en    (dout_en),
        .wr_pend    (wr_pend),
        .commit     (commit),
        .commit_addr(commit_addr),
        .commit_data(commit_data)
    );

    nv_arrays #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_arrays (
        .clk      (clk),
        .wr_en    (commit),
        .wr_addr  (commit_addr),
        .wr_data  (commit_data),
        .rd_addr  (addr),
        .rd_data  (rd_data),
        .store_cp (mode == NV_STORE),
        .recall_cp(mode == NV_RECALL),
        .cp_idx   (cnt)
    );
endmodule

// File: tb/nvsram_ctrl_bench.sv
// Bench: a behavioural reference model is stepped on every rising edge and
// compared with the outputs 1 ns later; scenario tasks drive on falling edges.
module nvsram_ctrl_bench;
    localparam int AW = 9;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;
    localparam int ST_N = 520;
    localparam int RC_N = 530;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          supply_ok = 1'b1, sw_store = 1'b0;
    logic [DW-1:0] dout;
    logic          dout_en, busy;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    string cur = "R4";

    nvsram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .STORE_CYCLES(ST_N), .RECALL_CYCLES(RC_N))
    u_nvsram_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .supply_ok(supply_ok), .sw_store(sw_store),
        .dout(dout), .dout_en(dout_en), .busy(busy)
    );

    always #2 clk = ~clk;

    // Reference model state.
    logic [DW-1:0] m_w [DEPTH];
    logic [DW-1:0] m_s [DEPTH];
    bit            m_wk [DEPTH];
    bit            m_sk [DEPTH];
    int            left = 0;
    bit            rreq = 1, dirty = 0, pend = 0, sup_q = 0;
    logic [AW-1:0] pa = '0;
    logic [DW-1:0] pd = '0;
    bit            e_en = 0, e_known = 0;
    logic [DW-1:0] e_dout = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Step the model on each rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            left = 0; rreq = 1; dirty = 0; pend = 0; sup_q = 0;
            e_en = 0; e_dout = '0; e_known = 0;
        end else begin
            bit fall, wr_now, rd_now;
            int st;
            fall = sup_q && !supply_ok;
            if (fall) rreq = 1;
            if (left == 0) begin
                wr_now = !ce_n && !we_n;
                rd_now = !ce_n && !oe_n && we_n;
                st = 0;
                if (fall && (dirty || pend))      st = 1;
                else if (rreq && supply_ok)       st = 2;
                else if (sw_store && supply_ok)   st = 1;
                if (pend && (!wr_now || st != 0)) begin
                    m_w[pa] = pd; m_wk[pa] = 1; dirty = 1;
                end
                if (rd_now) begin
                    e_en = 1; e_dout = m_w[addr]; e_known = m_wk[addr];
                end else begin
                    e_en = 0; e_dout = '0; e_known = 1;
                end
                if (wr_now) begin pa = addr; pd = din; end
                pend = wr_now && (st == 0);
                if (st == 1) begin
                    for (int i = 0; i < DEPTH; i++) begin m_s[i] = m_w[i]; m_sk[i] = m_wk[i]; end
                    left = ST_N; dirty = 0;
                end else if (st == 2) begin
                    for (int i = 0; i < DEPTH; i++) begin m_w[i] = m_s[i]; m_wk[i] = m_sk[i]; end
                    left = RC_N; dirty = 0; rreq = 0;
                end
            end else begin
                left--; e_en = 0; e_dout = '0; e_known = 1; pend = 0;
            end
            sup_q = supply_ok;
        end
    end

    // Compare outputs with the model shortly after every rising edge.
    always @(posedge clk) begin
        #1;
        check(busy == (left > 0), cur, "busy", busy, left > 0);
        check(dout_en == e_en, cur, "dout_en", dout_en, e_en);
        if (e_known) check(dout == e_dout, cur, "dout", dout, e_dout);
    end

    // Watchdog.
    initial begin
        #600000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input int hold);
        @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; addr = a; din = d;
        repeat (hold - 1) @(negedge clk);
        @(negedge clk); we_n = 1; ce_n = 1;
    endtask

    task automatic rd_expect(input logic [AW-1:0] a, input logic [DW-1:0] v, input string req);
        @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = a;
        @(negedge clk);
        check(dout_en == 1'b1 && dout == v, req, "read data", dout, v);
        ce_n = 1; oe_n = 1;
    endtask

    task automatic busy_len(input int n, input string req);
        int k = 0;
        while (busy) begin k++; @(negedge clk); end
        check(k == n, req, "busy length", k, n);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R4: power-up recall.
        cur = "R4";
        @(negedge clk);
        check(busy == 1'b1, "R4", "recall after reset", busy, 1);
        busy_len(RC_N, "R4");

        // R2: writes including a held write with data change.
        cur = "R2";
        wr(9'h000, 8'h3C, 1);
        @(negedge clk); ce_n = 0; we_n = 0; addr = 9'h1FF; din = 8'h01;
        @(negedge clk); din = 8'hC3;
        @(negedge clk); we_n = 1; ce_n = 1;
        wr(9'h0A5, 8'h5A, 3);
        // R2: read in the commit cycle returns the new byte.
        @(negedge clk); ce_n = 0; we_n = 0; addr = 9'h0F0; din = 8'h6E;
        @(negedge clk); we_n = 1; oe_n = 0;
        @(negedge clk);
        check(dout_en && dout == 8'h6E, "R2", "commit-cycle read", dout, 8'h6E);
        ce_n = 1; oe_n = 1;

        // R1: reads.
        cur = "R1";
        rd_expect(9'h000, 8'h3C, "R1");
        rd_expect(9'h1FF, 8'hC3, "R2");
        rd_expect(9'h0A5, 8'h5A, "R1");
        @(negedge clk);
        check(dout_en == 1'b0 && dout == 8'h00, "R1", "idle output", dout, 0);

        // R3: write strobe blanks the output while output enable stays low.
        cur = "R3";
        @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = 9'h055;
        @(negedge clk); we_n = 0; din = 8'h77;
        @(negedge clk);
        check(dout_en == 1'b0, "R3", "blanked by we_n", dout_en, 0);
        we_n = 1; ce_n = 1; oe_n = 1;
        rd_expect(9'h055, 8'h77, "R3");

        // R5: software store.
        cur = "R5";
        @(negedge clk); sw_store = 1;
        @(negedge clk); sw_store = 0;
        check(busy == 1'b1, "R5", "store started", busy, 1);
        busy_len(ST_N, "R5");

        // R7: dirty store on supply loss.
        cur = "R7";
        wr(9'h000, 8'h11, 1);
        @(negedge clk); supply_ok = 0;
        @(negedge clk);
        check(busy == 1'b1, "R7", "store on supply loss", busy, 1);
        busy_len(ST_N, "R7");

        // R6: software store ignored with low supply.
        cur = "R6";
        @(negedge clk); sw_store = 1;
        @(negedge clk); sw_store = 0;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R6", "store blocked", busy, 0);

        // R8: recall on return; R7 data kept.
        cur = "R8";
        supply_ok = 1;
        @(negedge clk);
        check(busy == 1'b1, "R8", "recall on return", busy, 1);
        busy_len(RC_N, "R8");
        rd_expect(9'h000, 8'h11, "R8");
        rd_expect(9'h1FF, 8'hC3, "R8");

        // R7: clean state, no store on supply loss.
        cur = "R7";
        @(negedge clk); supply_ok = 0;
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R7", "clean, no store", busy, 0);
        cur = "R8";
        supply_ok = 1;
        @(negedge clk);
        check(busy == 1'b1, "R8", "recall after clean dip", busy, 1);
        busy_len(RC_N, "R8");

        // R9: accesses during a store are ignored.
        cur = "R9";
        @(negedge clk); sw_store = 1;
        @(negedge clk); sw_store = 0;
        ce_n = 0; we_n = 0; addr = 9'h0A5; din = 8'hEE;
        repeat (3) @(negedge clk);
        we_n = 1; oe_n = 0;
        repeat (2) @(negedge clk);
        check(dout_en == 1'b0, "R9", "no output while busy", dout_en, 0);
        ce_n = 1; oe_n = 1;
        busy_len(ST_N - 5, "R9");
        rd_expect(9'h0A5, 8'h5A, "R9");

        // R7: write still in progress at supply fall is saved.
        cur = "R7";
        @(negedge clk); ce_n = 0; we_n = 0; addr = 9'h1FF; din = 8'h99;
        @(negedge clk); supply_ok = 0;
        @(negedge clk); we_n = 1; ce_n = 1;
        check(busy == 1'b1, "R7", "store with write in flight", busy, 1);
        busy_len(ST_N, "R7");
        supply_ok = 1;
        @(negedge clk);
        busy_len(RC_N, "R8");
        rd_expect(9'h1FF, 8'h99, "R7");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule